// File: doc/BRIEF.md
# Multi-Mode Serial Baud Generator

This block turns a reference clock and a 16-bit rate value into the timing strobes a serial port needs. It produces an oversampling strobe, a strobe once per data bit, and a square bit clock for synchronous transfers. It has three engines, and the mode inputs choose one of them. The same rate value is read in a different way by each engine.

- **Phase-accumulator engine.** A 16-bit accumulator adds (65536 − rate) on every reference clock. Each carry out is one oversampling strobe.
- **Fractional-divider engine.** An integer counter uses the lower 13 bits of the rate value as its divisor. The upper 3 bits give a fraction in eighths, which is reached by dithering.
- **Synchronous engine.** An 8-bit divider toggles a bit clock.

The rate value is written through a simple write port, and only while the block is disabled. Mode inputs are expected to stay constant while the block is enabled. All strobes are registered outputs.

Top module: `baud_gen`

## Requirements
- R1: The rate value resets to 0x0000. A write with `wr_en` high while `en` is low loads `wr_data` on that clock edge.
- R2: A write while `en` is high is ignored. The output timing keeps following the earlier rate value.
- R3: With `sync_mode`=0 and an accumulator code, each clock adds 65536−rate to a 16-bit accumulator. A carry gives one `os_tick` in the next cycle, so rate 0 gives a tick every cycle and rate 32768 gives one every 2 cycles.
- R4: Accumulator codes set the oversampling factor S. Code 0 gives S=16, code 2 gives S=8 and code 4 gives S=3. Codes 5, 6 and 7 act as code 0.
- R5: Codes 1 (S=16) and 3 (S=8) select the fractional engine. One oversampling period lasts D reference clocks, where D is rate[12:0] and a value of 0 is taken as 1. A 3-bit accumulator adds FP (rate[15:13]) at the end of each period, and each overflow lengthens the next period by one clock.
- R6: In both asynchronous engines, `bit_tick` is high together with every S-th `os_tick`, counted from the moment of enabling.
- R7: With `sync_mode`=1, only rate[7:0]=B is used. `bit_clk` starts low and toggles every B+1 clocks, giving a period of 2(B+1). `bit_tick` pulses in the cycle where `bit_clk` falls, and `os_tick` stays low.
- R8: While `en` is low, every counter is held at zero. From the cycle after the first clock edge with `en` low, all three outputs are low. The first strobe can appear in the cycle after the first enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Engine run enable |
| sync_mode | input | 1 | 1 selects the synchronous bit-clock engine |
| samp_code | input | 3 | Sample-rate code (asynchronous engine and S) |
| wr_en | input | 1 | Rate write strobe |
| wr_data | input | 16 | Rate write value |
| os_tick | output | 1 | Oversampling strobe |
| bit_tick | output | 1 | Once-per-bit strobe |
| bit_clk | output | 1 | Synchronous bit clock |

## Verification
Every output is registered, so a result caused by the inputs seen at clock edge N is due in the cycle after edge N. The bench drives inputs on the falling edge. A behavioural model steps on each rising edge from the same inputs and is compared with the outputs on every falling edge, so no result is sampled in the cycle it forms. Strobe intervals are also measured between the second and third `bit_tick` after each enable. This skips the first, partial period and checks the steady-state period against the rate formula.

// File: rtl/baud_pkg.sv
// Shared types for the baud generator: engine selection and decode of the
// sample-rate code into engine and oversampling factor.
package baud_pkg;
    typedef enum logic [1:0] {
        ENG_ACC  = 2'd0,
        ENG_FRAC = 2'd1,
        ENG_SYNC = 2'd2
    } engine_e;

    typedef struct packed {
        engine_e    eng;
        logic [4:0] s_fac;
    } mode_t;

    // Decode mode pins; unlisted codes fall back to accumulator, S=16.
    function automatic mode_t decode_mode(input logic sync_sel, input logic [2:0] code);
        mode_t m;
        m.eng   = ENG_ACC;
        m.s_fac = 5'd16;
        if (sync_sel) begin
            m.eng = ENG_SYNC;
        end else begin
            case (code)
                3'd1: begin m.eng = ENG_FRAC; m.s_fac = 5'd16; end
                3'd2: m.s_fac = 5'd8;
                3'd3: begin m.eng = ENG_FRAC; m.s_fac = 5'd8; end
                3'd4: m.s_fac = 5'd3;
                default: m.s_fac = 5'd16;
            endcase
        end
        return m;
    endfunction
endpackage

// File: rtl/baud_rate_reg.sv
// Rate value holding register. Loads only while the engines are stopped.
// Assumes wr_en is a single-cycle or level strobe in the clk domain.
module baud_rate_reg #(
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr_en,
    input  logic [RATE_W-1:0] wr_data,
    output logic [RATE_W-1:0] rate
);
    // Hold rate; accept writes only when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)            rate <= '0;
        else if (wr_en && !en) rate <= wr_data;
    end
endmodule

// File: rtl/baud_acc_eng.sv
// Phase-accumulator engine: adds (2^RATE_W - rate) each clock; a carry out
// is an oversampling event (combinational, same cycle as the add).
// Assumes run is low whenever this engine is not selected.
module baud_acc_eng #(
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              evt
);
    logic [RATE_W-1:0] acc;
    logic [RATE_W:0]   inc;
    logic [RATE_W:0]   sum;

    // Increment and carry for this cycle.
    always_comb begin
        inc = {1'b1, {RATE_W{1'b0}}} - {1'b0, rate};
        sum = {1'b0, acc} + inc;
        evt = run && sum[RATE_W];
    end

    // Accumulator, held at zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) acc <= '0;
        else                acc <= sum[RATE_W-1:0];
    end
endmodule

// File: rtl/baud_frac_eng.sv
// Fractional divider engine: period = D (+1 when the eighths accumulator
// overflowed at the end of the previous period). D of zero acts as one.
// Assumes RATE_W > FRAC_W; upper FRAC_W bits carry the fraction.
module baud_frac_eng #(
    parameter int RATE_W = 16,
    parameter int FRAC_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              evt
);
    localparam int INT_W = RATE_W - FRAC_W;

    logic [INT_W:0]    cnt;
    logic [FRAC_W-1:0] frac;
    logic              stretch;
    logic [INT_W:0]    len;
    logic [INT_W-1:0]  div;
    logic [FRAC_W-1:0] fp;
    logic [FRAC_W:0]   fsum;

    // Effective period length and terminal detect.
    always_comb begin
        div  = rate[INT_W-1:0];
        fp   = rate[RATE_W-1:INT_W];
        len  = (div == '0) ? {{INT_W{1'b0}}, 1'b1} : {1'b0, div};
        len  = len + {{INT_W{1'b0}}, stretch};
        fsum = {1'b0, frac} + {1'b0, fp};
        evt  = run && (cnt == len - 1'b1);
    end

    // Period counter and dither accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt     <= '0;
            frac    <= '0;
            stretch <= 1'b0;
        end else if (evt) begin
            cnt     <= '0;
            frac    <= fsum[FRAC_W-1:0];
            stretch <= fsum[FRAC_W];
        end else begin
            cnt     <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/baud_sync_eng.sv
// Synchronous engine: toggles a bit clock every (B+1) clocks using the
// low SYNC_W bits of the rate value; flags the falling toggle.
module baud_sync_eng #(
    parameter int RATE_W = 16,
    parameter int SYNC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              fall_evt,
    output logic              bclk
);
    logic [SYNC_W-1:0] cnt;
    logic              term;

    // Terminal count and falling-toggle detect.
    always_comb begin
        term     = run && (cnt == rate[SYNC_W-1:0]);
        fall_evt = term && bclk;
    end

    // Divider counter and bit clock, low while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt  <= '0;
            bclk <= 1'b0;
        end else if (term) begin
            cnt  <= '0;
            bclk <= ~bclk;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/baud_gen.sv
// Baud generator top: selects one of three engines from the mode pins,
// counts oversampling events into bit strobes and registers the outputs.
// Assumes sync_mode and samp_code are stable while en is high.
module baud_gen
    import baud_pkg::*;
#(
    parameter int RATE_W = 16,
    parameter int FRAC_W = 3,
    parameter int SYNC_W = 8,
    parameter int OSC_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              sync_mode,
    input  logic [2:0]        samp_code,
    input  logic              wr_en,
    input  logic [RATE_W-1:0] wr_data,
    output logic              os_tick,
    output logic              bit_tick,
    output logic              bit_clk
);
    mode_t             mode;
    logic [RATE_W-1:0] rate_q;
    logic              acc_evt, frac_evt, sync_fall, os_evt;
    logic [OSC_W-1:0]  os_cnt;
    logic [OSC_W-1:0]  s_last;

    // Mode decode and event select.
    always_comb begin
        mode   = decode_mode(sync_mode, samp_code);
        s_last = OSC_W'(mode.s_fac) - 1'b1;
        os_evt = (mode.eng == ENG_FRAC) ? frac_evt : acc_evt;
    end

    baud_rate_reg #(.RATE_W(RATE_W)) u_rate (
        .clk(clk), .rst_n(rst_n), .en(en),
        .wr_en(wr_en), .wr_data(wr_data), .rate(rate_q)
    );

    baud_acc_eng #(.RATE_W(RATE_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .run(en && mode.eng == ENG_ACC),
        .rate(rate_q), .evt(acc_evt)
    );

    baud_frac_eng #(.RATE_W(RATE_W), .FRAC_W(FRAC_W)) u_frac (
        .clk(clk), .rst_n(rst_n), .run(en && mode.eng == ENG_FRAC),
        .rate(rate_q), .evt(frac_evt)
    );

    baud_sync_eng #(.RATE_W(RATE_W), .SYNC_W(SYNC_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .run(en && mode.eng == ENG_SYNC),
        .rate(rate_q), .fall_evt(sync_fall), .bclk(bit_clk)
    );

    // Oversample counter and registered strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            os_cnt   <= '0;
            os_tick  <= 1'b0;
            bit_tick <= 1'b0;
        end else if (mode.eng == ENG_SYNC) begin
            os_cnt   <= '0;
            os_tick  <= 1'b0;
            bit_tick <= sync_fall;
        end else begin
            os_tick  <= os_evt;
            bit_tick <= os_evt && (os_cnt == s_last);
            if (os_evt) os_cnt <= (os_cnt == s_last) ? '0 : os_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/baud_gen_chk.sv
// Property checker for baud_gen, bound to every instance.
module baud_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        en,
    input logic        sync_mode,
    input logic [15:0] rate,
    input logic        os_tick,
    input logic        bit_tick,
    input logic        bit_clk
);
    // R2
    rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> rate == $past(rate));
    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!os_tick && !bit_tick && !bit_clk));
    // R6
    bit_with_os_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && !sync_mode) |-> os_tick);
    // R7
    sync_no_os_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && $past(sync_mode)) |-> !os_tick);
    // R7
    sync_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && sync_mode) |-> $fell(bit_clk));
endmodule

bind baud_gen baud_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .sync_mode(sync_mode),
    .rate(rate_q), .os_tick(os_tick), .bit_tick(bit_tick), .bit_clk(bit_clk)
);

// File: tb/tb_baud_gen.sv
module tb_baud_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        sync_mode = 1'b0;
    logic [2:0]  samp_code = 3'd0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = 16'd0;
    logic        os_tick, bit_tick, bit_clk;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    baud_gen dut (
        .clk(clk), .rst_n(rst_n), .en(en), .sync_mode(sync_mode),
        .samp_code(samp_code), .wr_en(wr_en), .wr_data(wr_data),
        .os_tick(os_tick), .bit_tick(bit_tick), .bit_clk(bit_clk)
    );

    // Behavioural reference state
    int m_rate = 0, m_acc = 0, m_cnt = 0, m_frac = 0, m_str = 0, m_osc = 0;
    bit e_os = 0, e_bit = 0, e_clk = 0;

    function automatic int s_of(input logic sm, input logic [2:0] c);
        if (sm) return 0;
        case (c)
            3'd2, 3'd3: return 8;
            3'd4:       return 3;
            default:    return 16;
        endcase
    endfunction

    always @(posedge clk) begin
        bit ev;
        int s, d, len, sum;
        ev = 0;
        if (!rst_n || !en) begin
            if (!rst_n) m_rate = 0;
            else if (wr_en) m_rate = int'(wr_data);
            m_acc = 0; m_cnt = 0; m_frac = 0; m_str = 0; m_osc = 0;
            e_os = 0; e_bit = 0; e_clk = 0;
        end else if (sync_mode) begin
            e_os = 0; e_bit = 0;
            if (m_cnt == (m_rate % 256)) begin
                m_cnt = 0; e_bit = e_clk; e_clk = !e_clk;
            end else m_cnt++;
        end else begin
            s = s_of(sync_mode, samp_code);
            if (samp_code == 3'd1 || samp_code == 3'd3) begin
                d = m_rate % 8192;
                if (d == 0) d = 1;
                len = d + m_str;
                if (m_cnt == len - 1) begin
                    ev = 1; m_cnt = 0;
                    sum = m_frac + m_rate / 8192;
                    m_frac = sum % 8; m_str = sum / 8;
                end else m_cnt++;
            end else begin
                sum = m_acc + 65536 - m_rate;
                ev = (sum >= 65536);
                m_acc = sum % 65536;
            end
            e_os = ev;
            e_bit = ev && (m_osc == s - 1);
            if (ev) m_osc = (m_osc == s - 1) ? 0 : m_osc + 1;
        end
    end

    function automatic string tag_now();
        if (!en) return "R8";
        if (sync_mode) return "R7";
        if (samp_code == 3'd1 || samp_code == 3'd3) return "R5";
        return "R3";
    endfunction

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            tests++;
            if ({os_tick, bit_tick, bit_clk} !== {e_os, e_bit, e_clk}) begin
                fails++;
                $display("FAIL %s/R6 cycle %0d: got os=%b bit=%b clk=%b exp os=%b bit=%b clk=%b",
                         tag_now(), cycles, os_tick, bit_tick, bit_clk, e_os, e_bit, e_clk);
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [15:0] r, input logic sm, input logic [2:0] c);
        @(negedge clk);
        en = 1'b0; wr_en = 1'b1; wr_data = r; sync_mode = sm; samp_code = c;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        en = 1'b1;
    endtask

    // Interval between the second and third bit strobes.
    task automatic measure(input int exp, input string req);
        int t, last, n, got;
        t = 0; last = 0; n = 0; got = -1;
        while (n < 3 && t < 5000) begin
            @(negedge clk);
            t++;
            if (bit_tick) begin
                if (n >= 1) got = t - last;
                last = t;
                n++;
            end
        end
        check(got == exp, req, got, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({os_tick, bit_tick, bit_clk} == 3'b000, "R8 reset outputs", int'({os_tick, bit_tick, bit_clk}), 0);
        // R1: reset rate 0 in accumulator S=16 gives a bit every 16
        en = 1'b1;
        measure(16, "R1 reset rate");
        cfg(16'h8000, 1'b0, 3'd0);  measure(32, "R3 rate 32768 S16");
        // R2: write while enabled ignored
        @(negedge clk); wr_en = 1'b1; wr_data = 16'h0000;
        @(negedge clk); wr_en = 1'b0;
        measure(32, "R2 write ignored");
        cfg(16'hC000, 1'b0, 3'd2);  measure(32, "R4 code2 S8");
        cfg(16'h0000, 1'b0, 3'd4);  measure(3,  "R4 code4 S3");
        cfg(16'h0000, 1'b0, 3'd5);  measure(16, "R4 code5 S16");
        cfg(16'h8000, 1'b0, 3'd7);  measure(32, "R4 code7 S16");
        cfg(16'h0004, 1'b0, 3'd1);  measure(64, "R5 D4 FP0 S16");
        cfg(16'h8004, 1'b0, 3'd1);  measure(72, "R5 D4 FP4 S16");
        cfg(16'hE002, 1'b0, 3'd3);  measure(23, "R5 D2 FP7 S8");
        cfg(16'h0000, 1'b0, 3'd3);  measure(8,  "R5 D0 as 1");
        cfg(16'h1203, 1'b1, 3'd0);  measure(8,  "R7 sync B3 low byte");
        cfg(16'h0000, 1'b1, 3'd0);  measure(2,  "R7 sync B0");
        // R8: disable quiets outputs
        @(negedge clk); en = 1'b0;
        repeat (2) @(negedge clk);
        check({os_tick, bit_tick, bit_clk} == 3'b000, "R8 disabled", int'({os_tick, bit_tick, bit_clk}), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule